// File: doc/BRIEF.md
# Stream pre-trigger advance aligner

This block sits in a sample stream in which every beat carries three payload fields together: sample data, a timestamp and an information word. Each beat also carries three event markers: gate, sync and PPS. The block holds the payload back by a programmable number of accepted beats but passes the markers through on time. An event marker therefore leaves the block next to payload that was taken in earlier. Anything that captures from the marked beat onward gets a window of samples from before the event.

A single 32-bit control register sets the delay, counted in samples. The register sits at byte offset 0x0 of a small write/read port. Only bits 15:0 are used. A setting above 1023 acts as 1023. Every write to the register empties the delay history. The first beats after the write then refill it and produce no output, so a beat from before the change never comes out.

The input and output use valid/ready handshakes. One output register sits between them. Input is held off when that register is full and not being drained, and also in the cycle of a control write.

Top module: `stp_advance_aligner`

## Requirements
- R1: After reset, m_valid is 0, s_ready is 1 and the control register reads 0x00000000 at offset 0x0, which means a delay of zero.
- R2: With a delay of 0, every accepted beat comes out on the output in the next cycle, with its own payload and its own markers.
- R3: With an effective delay D, the output beat produced by accepted input beat n carries the data, timestamp and information of accepted input beat n−D, all three taken from that same earlier beat.
- R4: The markers on an output beat are those of the input beat that produced it, undelayed: s_evt/m_evt bit 0 is gate, bit 1 is sync and bit 2 is PPS.
- R5: After reset or after a control write, the first D accepted beats produce no output beat; every later accepted beat produces exactly one.
- R6: The register reads back bits 15:0 as written. When that value exceeds 1023, the effective delay is 1023.
- R7: Bits 31:16 of the register read as zero whatever was written. Reads at any offset other than 0x0 return zero. Writes at any offset other than 0x0 change neither the readback nor the delay, and they do not empty the history.
- R8: A control write empties the delay history. Output resumes only after D further beats under the new delay.
- R9: While m_valid is 1 and m_ready is 0, s_ready is 0 and the output beat stays unchanged. Otherwise s_ready is 1, except in the case of R10. No accepted beat is lost or duplicated.
- R10: In a cycle with a control write at offset 0x0, s_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_data | input | DATA_W | Input sample data |
| s_ts | input | TS_W | Input timestamp |
| s_info | input | INFO_W | Input information word |
| s_evt | input | 3 | Input markers: bit 0 gate, bit 1 sync, bit 2 PPS |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts output beat |
| m_data | output | DATA_W | Delayed sample data |
| m_ts | output | TS_W | Delayed timestamp |
| m_info | output | INFO_W | Delayed information word |
| m_evt | output | 3 | Undelayed markers |

## Verification
The hardest case to reach is the saturated depth. It needs an oversized register value followed by more than 1023 accepted beats with no control write in between. The stimulus writes a value above the limit, confirms the readback, and then streams 1100 beats at full rate; only the last 77 may appear at the output. A second hard case is a flush while the history is part-filled and a beat is held waiting at the input. The bench reaches it by rewriting the delay mid-stream while it holds s_valid high and applies random backpressure.

// File: rtl/stp_pkg.sv
package stp_pkg;
   // register port geometry
   localparam int REG_W = 32;
   localparam int CTL_W = 16;
   localparam logic [7:0] CTRL_OFF = 8'h00;
   // marker positions inside the event vector
   localparam int EVT_GATE = 0;
   localparam int EVT_SYNC = 1;
   localparam int EVT_PPS  = 2;
   localparam int EVT_N    = 3;
endpackage

// File: rtl/stp_ctrl_reg.sv
module stp_ctrl_reg
   import stp_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int PTR_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   output logic [PTR_W-1:0]  dly,
   output logic              flush
);
   localparam logic [PTR_W-1:0] MAX_DLY = {PTR_W{1'b1}};

   if (PTR_W > CTL_W) begin : g_bad_ptr
      $error("stp_ctrl_reg: PTR_W exceeds control field width");
   end
   if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
      $error("stp_ctrl_reg: ADDR_W out of range");
   end

   logic [CTL_W-1:0] ctl_q;
   logic             sel;

   assign sel   = (cfg_addr == ADDR_W'(CTRL_OFF));
   assign flush = cfg_wr & sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (flush) begin
         ctl_q <= cfg_wdata[CTL_W-1:0];
      end
   end

   // upper bits are zero-extended, other offsets read zero
   assign cfg_rdata = sel ? REG_W'(ctl_q) : '0;

   always_comb begin
      if (32'(ctl_q) > 32'(MAX_DLY)) begin
         dly = MAX_DLY;
      end else begin
         dly = ctl_q[PTR_W-1:0];
      end
   end
endmodule

// File: rtl/stp_delay_line.sv
module stp_delay_line #(
   parameter int PAY_W = 56,
   parameter int DEPTH = 1024,
   parameter int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             flush,
   input  logic [PTR_W-1:0] dly,
   input  logic [PAY_W-1:0] din,
   output logic             emit,
   output logic [PAY_W-1:0] dout
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("stp_delay_line: DEPTH must be a power of two, at least 2");
   end
   if (PTR_W != $clog2(DEPTH)) begin : g_bad_ptr
      $error("stp_delay_line: PTR_W must equal clog2(DEPTH)");
   end

   logic [PAY_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp;
   logic [PTR_W-1:0] fill;
   logic [PTR_W-1:0] rd_idx;
   logic             at_depth;

   assign at_depth = (fill == dly);
   assign emit     = push & at_depth;
   assign rd_idx   = wp - dly;

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wp] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp   <= '0;
         fill <= '0;
      end else begin
         if (push) begin
            wp <= wp + 1'b1;
         end
         if (flush) begin
            fill <= '0;
         end else if (push && !at_depth) begin
            fill <= fill + 1'b1;
         end
      end
   end

   // zero delay forwards the beat being written
   assign dout = (dly == '0) ? din : mem[rd_idx];
endmodule

// File: rtl/stp_out_stage.sv
module stp_out_stage #(
   parameter int PAY_W = 56,
   parameter int EVT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PAY_W-1:0] pay_in,
   input  logic [EVT_W-1:0] evt_in,
   input  logic             m_ready,
   output logic             m_valid,
   output logic [PAY_W-1:0] m_pay,
   output logic [EVT_W-1:0] m_evt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
      end else if (load) begin
         m_valid <= 1'b1;
      end else if (m_ready) begin
         m_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_pay <= '0;
      end else if (load) begin
         m_pay <= pay_in;
      end
   end

   for (genvar i = 0; i < EVT_W; i++) begin : g_evt
      logic evt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            evt_q <= 1'b0;
         end else if (load) begin
            evt_q <= evt_in[i];
         end
      end
      assign m_evt[i] = evt_q;
   end
endmodule

// File: rtl/stp_advance_aligner.sv
module stp_advance_aligner
   import stp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TS_W   = 16,
   parameter int INFO_W = 8,
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_data,
   input  logic [TS_W-1:0]   s_ts,
   input  logic [INFO_W-1:0] s_info,
   input  logic [EVT_N-1:0]  s_evt,
   output logic              m_valid,
   input  logic              m_ready,
   output logic [DATA_W-1:0] m_data,
   output logic [TS_W-1:0]   m_ts,
   output logic [INFO_W-1:0] m_info,
   output logic [EVT_N-1:0]  m_evt
);
   localparam int PAY_W = DATA_W + TS_W + INFO_W;
   localparam int PTR_W = $clog2(DEPTH);

   if (DATA_W < 1 || TS_W < 1 || INFO_W < 1) begin : g_bad_width
      $error("stp_advance_aligner: field widths must be positive");
   end

   logic [PTR_W-1:0] dly;
   logic             flush;
   logic             push;
   logic             emit;
   logic [PAY_W-1:0] pay_in;
   logic [PAY_W-1:0] pay_dly;
   logic [PAY_W-1:0] pay_out;

   assign s_ready = !flush && (!m_valid || m_ready);
   assign push    = s_valid && s_ready;
   assign pay_in  = {s_data, s_ts, s_info};

   stp_ctrl_reg #(
      .ADDR_W (ADDR_W),
      .PTR_W  (PTR_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .dly       (dly),
      .flush     (flush)
   );

   stp_delay_line #(
      .PAY_W (PAY_W),
      .DEPTH (DEPTH),
      .PTR_W (PTR_W)
   ) line_i (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .flush (flush),
      .dly   (dly),
      .din   (pay_in),
      .emit  (emit),
      .dout  (pay_dly)
   );

   stp_out_stage #(
      .PAY_W (PAY_W),
      .EVT_W (EVT_N)
   ) out_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (emit),
      .pay_in  (pay_dly),
      .evt_in  (s_evt),
      .m_ready (m_ready),
      .m_valid (m_valid),
      .m_pay   (pay_out),
      .m_evt   (m_evt)
   );

   assign m_data = pay_out[PAY_W-1 -: DATA_W];
   assign m_ts   = pay_out[INFO_W +: TS_W];
   assign m_info = pay_out[INFO_W-1:0];
endmodule

// File: rtl/stp_advance_aligner_chk.sv
module stp_advance_aligner_chk
   import stp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int TS_W   = 16,
   parameter int INFO_W = 8,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic [REG_W-1:0]  cfg_rdata,
   input logic              s_ready,
   input logic              m_valid,
   input logic              m_ready,
   input logic [DATA_W-1:0] m_data,
   input logic [TS_W-1:0]   m_ts,
   input logic [INFO_W-1:0] m_info,
   input logic [EVT_N-1:0]  m_evt
);
   logic hit;
   assign hit = cfg_wr && (cfg_addr == ADDR_W'(CTRL_OFF));

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_ts)
                                 && $stable(m_info) && $stable(m_evt)));

   // R9
   stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |-> !s_ready);

   // R9
   idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!m_valid && !hit) |-> s_ready);

   // R10
   cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !s_ready);

   // R5
   cfg_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !$rose(m_valid));

   // R7
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[REG_W-1:CTL_W] == '0);
endmodule

bind stp_advance_aligner stp_advance_aligner_chk #(
   .DATA_W (DATA_W),
   .TS_W   (TS_W),
   .INFO_W (INFO_W),
   .ADDR_W (ADDR_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_addr  (cfg_addr),
   .cfg_rdata (cfg_rdata),
   .s_ready   (s_ready),
   .m_valid   (m_valid),
   .m_ready   (m_ready),
   .m_data    (m_data),
   .m_ts      (m_ts),
   .m_info    (m_info),
   .m_evt     (m_evt)
);

// File: tb/stp_advance_aligner_tb_top.sv
module stp_advance_aligner_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int TW = 16;
   localparam int IW = 8;
   localparam int EW = 3;
   localparam int AW = 4;
   localparam int PW = DW + TW + IW;
   localparam int MAXD = 1023;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          s_valid = 1'b0;
   logic          s_ready;
   logic [DW-1:0] s_data = '0;
   logic [TW-1:0] s_ts = '0;
   logic [IW-1:0] s_info = '0;
   logic [EW-1:0] s_evt = '0;
   logic          m_valid;
   logic          m_ready = 1'b1;
   logic [DW-1:0] m_data;
   logic [TW-1:0] m_ts;
   logic [IW-1:0] m_info;
   logic [EW-1:0] m_evt;

   always #(CLK_PERIOD/2) clk = ~clk;

   stp_advance_aligner #(
      .DATA_W (DW), .TS_W (TW), .INFO_W (IW), .DEPTH (1024), .ADDR_W (AW)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .cfg_wr (cfg_wr), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
      .s_valid (s_valid), .s_ready (s_ready), .s_data (s_data), .s_ts (s_ts),
      .s_info (s_info), .s_evt (s_evt),
      .m_valid (m_valid), .m_ready (m_ready), .m_data (m_data), .m_ts (m_ts),
      .m_info (m_info), .m_evt (m_evt)
   );

   int tests = 0;
   int fails = 0;
   int out_hs = 0;
   int beat_cnt = 0;
   bit done = 1'b0;
   bit acc_seen = 1'b0;
   string ptag = "R1";

   // reference model state
   int            eff_d = 0;
   logic [PW-1:0] hist[$];
   logic          e_mv = 1'b0;
   logic [PW-1:0] e_pay = '0;
   logic [EW-1:0] e_evt = '0;

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s (phase %s) t=%0t act=%h exp=%h", req, ptag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         e_mv = 1'b0;
         hist.delete();
         eff_d = 0;
         acc_seen = 1'b0;
      end else begin
         bit hit, rdy, acc;
         hit = cfg_wr && (cfg_addr == '0);
         rdy = !hit && (!e_mv || m_ready);
         chk(s_ready == rdy, "R9", 64'(s_ready), 64'(rdy));
         chk(m_valid == e_mv, "R5", 64'(m_valid), 64'(e_mv));
         if (e_mv) begin
            chk({m_data, m_ts, m_info} == e_pay, "R3", 64'({m_data, m_ts, m_info}), 64'(e_pay));
            chk(m_evt == e_evt, "R4", 64'(m_evt), 64'(e_evt));
         end
         if (m_valid && m_ready) out_hs++;
         acc = s_valid && rdy;
         acc_seen = acc;
         if (hit) begin
            eff_d = (int'(cfg_wdata[15:0]) > MAXD) ? MAXD : int'(cfg_wdata[15:0]);
            hist.delete();
            if (m_ready) e_mv = 1'b0;
         end else if (acc) begin
            hist.push_back({s_data, s_ts, s_info});
            if (hist.size() > eff_d) begin
               e_pay = hist.pop_front();
               e_evt = s_evt;
               e_mv  = 1'b1;
            end else if (m_ready) begin
               e_mv = 1'b0;
            end
         end else if (m_ready) begin
            e_mv = 1'b0;
         end
      end
   end

   task automatic new_beat();
      beat_cnt++;
      s_data = {beat_cnt[15:0], ~beat_cnt[15:0]};
      s_ts   = TW'(beat_cnt * 3);
      s_info = IW'(beat_cnt) ^ 8'h5A;
      s_evt  = EW'($urandom_range(7));
   endtask

   task automatic stream(int n, int vpct, int rpct);
      int got = 0;
      while (got < n) begin
         @(posedge clk); #1;
         if (acc_seen) got++;
         if (acc_seen || !s_valid) begin
            if (got >= n) s_valid = 1'b0;
            else begin
               s_valid = ($urandom_range(99) < vpct);
               if (s_valid) new_beat();
            end
         end
         m_ready = ($urandom_range(99) < rpct);
      end
   endtask

   task automatic drain(int k);
      @(posedge clk); #1;
      m_ready = 1'b1;
      if (acc_seen) s_valid = 1'b0;
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic cfg_write(logic [AW-1:0] a, logic [31:0] d);
      @(posedge clk); #1;
      cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
      @(posedge clk); #1;
      cfg_wr = 1'b0; cfg_addr = '0;
   endtask

   task automatic cfg_read(logic [AW-1:0] a, logic [31:0] exp, string req);
      @(posedge clk); #1;
      cfg_addr = a;
      @(negedge clk);
      chk(cfg_rdata == exp, req, 64'(cfg_rdata), 64'(exp));
      @(posedge clk); #1;
      cfg_addr = '0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL R9 watchdog expired act=running exp=done");
         finish_run();
      end
   end

   initial begin
      int base;
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(m_valid == 1'b0, "R1", 64'(m_valid), 64'd0);
      chk(s_ready == 1'b1, "R1", 64'(s_ready), 64'd1);
      chk(cfg_rdata == 32'h0, "R1", 64'(cfg_rdata), 64'd0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R2: zero delay, one-cycle pass-through
      ptag = "R2";
      base = out_hs;
      stream(30, 80, 100);
      drain(5);
      chk(out_hs - base == 30, "R2", 64'(out_hs - base), 64'd30);

      // R3: delay 5 under backpressure
      ptag = "R3";
      cfg_write('0, 32'd5);
      stream(60, 70, 60);
      drain(10);

      // R8: rewrite mid-stream while history is part-filled
      ptag = "R8";
      stream(3, 100, 100);
      cfg_write('0, 32'd3);
      base = out_hs;
      stream(30, 90, 70);
      drain(10);
      chk(out_hs - base == 27, "R8", 64'(out_hs - base), 64'd27);

      // R10: write while a beat waits at the input
      ptag = "R10";
      @(posedge clk); #1;
      new_beat(); s_valid = 1'b1; m_ready = 1'b1;
      cfg_write('0, 32'd2);
      stream(20, 80, 80);
      drain(10);

      // R6: oversized setting saturates at 1023
      ptag = "R6";
      cfg_write('0, 32'hABCD_1234);
      cfg_read('0, 32'h0000_1234, "R6");
      base = out_hs;
      stream(1100, 100, 100);
      drain(5);
      chk(out_hs - base == 77, "R6", 64'(out_hs - base), 64'd77);

      // R7: write elsewhere ignored, no flush
      ptag = "R7";
      cfg_write(4'h4, 32'h0000_0002);
      cfg_read('0, 32'h0000_1234, "R7");
      cfg_read(4'h4, 32'h0, "R7");
      base = out_hs;
      stream(10, 100, 100);
      drain(5);
      chk(out_hs - base == 10, "R7", 64'(out_hs - base), 64'd10);

      // R5: delay 1 absorbs one beat after the write
      ptag = "R5";
      cfg_write('0, 32'd1);
      base = out_hs;
      stream(8, 60, 50);
      drain(10);
      chk(out_hs - base == 7, "R5", 64'(out_hs - base), 64'd7);

      done = 1'b1;
      finish_run();
   end
endmodule